// File: doc/BRIEF.md
# Toll Booth Payment Controller

This block controls a single toll lane. A car sensor tells it when a vehicle stands at the booth. A 2-bit coin code reports each coin that has already been validated upstream. The controller adds the coins toward a fixed toll and shows one of three states on its lamps:

- **Red:** the car must wait.
- **Green:** the car may go.
- **Red with alarm:** the car drove away without paying in full.

The design is a Moore machine with a separate credit register. Lamps are decoded from the registered state, and the credit register is visible as an output. Each input cycle therefore shows its effect on the outputs one clock edge later. Control drives the credit datapath through two strobes: clear and accept. The datapath reports back whether the coin accepted in the current cycle completes the toll.

Top module: `tollBoothCtrl`

## Requirements
- R1: A synchronous active-high reset, applied at any time, leaves the lamps low and `creditLevel` at 0 after the next clock edge.
- R2: While a car is present and the toll is unpaid, coin code 00 adds 0, code 01 adds 5, code 10 adds 10 and code 11 adds 25 to the credit. The credit is sampled once per cycle, and the sum shows on `creditLevel` after the next clock edge.
- R3: While a car is present and the credit is below the toll of 35, `lampRed` is 1 and `lampGreen` and `lampAlarm` are 0. Red and green are never both 1.
- R4: When the credit reaches 35, with the toll met either exactly or by overpaying, `lampGreen` rises and `lampRed` falls at the next clock edge.
- R5: Credit saturates at 35. Overpayment is dropped, so `creditLevel` never exceeds 35.
- R6: With no car present, coins have no effect: `creditLevel` stays 0 and the lamps do not change.
- R7: When a paid car leaves (car input low while green), all lamps are low and the credit is 0 after the next edge.
- R8: When a car leaves before paying in full, `lampRed` and `lampAlarm` are both 1 and the credit is 0 after the next edge. This lasts for as long as no car is present.
- R9: A car arriving while the alarm is on clears the alarm and starts a new transaction from zero credit, with red lit.
- R10: Coins inserted after the toll is met do not change the credit or the lamps.
- R11: A coin presented in the very first cycle a car is seen is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| carHere | input | 1 | High while a vehicle is at the booth |
| coinCode | input | 2 | Validated coin for this cycle (00 none, 01 = 5, 10 = 10, 11 = 25) |
| lampRed | output | 1 | Stop indication |
| lampGreen | output | 1 | Go indication |
| lampAlarm | output | 1 | Car left without paying the full toll |
| creditLevel | output | CW (6) | Credit accumulated for the current car |

## Verification
A corrupted credit value shows on `creditLevel` one edge after the coin that caused it. If it pushes the credit across 35 too early or too late, the red-to-green change moves by at least one cycle. A wrong state shows in the lamp pattern at the very next edge, because the lamps decode directly from the state register. The bench compares every cycle, so an alarm that fails to latch, lingers after a new car arrives, or misses a departure is caught within one clock.

// File: rtl/tollPkg.sv
package tollPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OWE   = 2'd1,
    ST_PAID  = 2'd2,
    ST_ALARM = 2'd3
  } gateState_t;

  // strobes from control to the credit datapath
  typedef struct packed {
    logic clear;   // zero the credit register
    logic accept;  // add this cycle's coin, saturating
  } creditCtl_t;

endpackage

// File: rtl/tollCredit.sv
module tollCredit
  import tollPkg::*;
#(
  parameter int TOLL   = 35,
  parameter int COIN_A = 5,
  parameter int COIN_B = 10,
  parameter int COIN_C = 25,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  creditCtl_t    ctl,
  input  logic [1:0]    coinCode,
  output logic [CW-1:0] credit,
  output logic          willPay
);

  localparam logic [CW:0] TOLL_W  = (CW+1)'(TOLL);
  localparam logic [CW:0] COINA_W = (CW+1)'(COIN_A);
  localparam logic [CW:0] COINB_W = (CW+1)'(COIN_B);
  localparam logic [CW:0] COINC_W = (CW+1)'(COIN_C);

  logic [CW:0]   coinVal;
  logic [CW:0]   sum;
  logic [CW-1:0] satSum;

  always_comb begin
    unique case (coinCode)
      2'b01:   coinVal = COINA_W;
      2'b10:   coinVal = COINB_W;
      2'b11:   coinVal = COINC_W;
      default: coinVal = '0;
    endcase
  end

  assign sum     = {1'b0, credit} + coinVal;
  assign satSum  = (sum >= TOLL_W) ? TOLL_W[CW-1:0] : sum[CW-1:0];
  assign willPay = ctl.accept && (sum >= TOLL_W);

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) credit <= '0;
    else if (ctl.accept)  credit <= satSum;
  end

  // R5
  credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, credit} <= TOLL_W);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> credit == '0);

  // R2
  null_coin_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.accept && coinCode == 2'b00 && !ctl.clear) |=> $stable(credit));

endmodule

// File: rtl/tollFsm.sv
module tollFsm
  import tollPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       carHere,
  input  logic       willPay,
  output creditCtl_t ctl,
  output logic       lampRed,
  output logic       lampGreen,
  output logic       lampAlarm
);

  gateState_t state, stateNext;

  always_comb begin
    ctl.clear  = !carHere;
    ctl.accept = carHere && (state != ST_PAID);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_ALARM: if (carHere) stateNext = willPay ? ST_PAID : ST_OWE;
      ST_OWE: begin
        if (!carHere)     stateNext = ST_ALARM;
        else if (willPay) stateNext = ST_PAID;
      end
      ST_PAID: if (!carHere) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign lampRed   = (state == ST_OWE) || (state == ST_ALARM);
  assign lampGreen = (state == ST_PAID);
  assign lampAlarm = (state == ST_ALARM);

  // R3
  lamp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lampRed && lampGreen));

  // R4
  pay_go_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OWE && carHere && willPay) |=> lampGreen);

  // R8
  runaway_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OWE && !carHere) |=> (lampAlarm && lampRed));

  // R7
  leave_paid_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAID && !carHere) |=> !(lampRed || lampGreen || lampAlarm));

endmodule

// File: rtl/tollBoothCtrl.sv
module tollBoothCtrl
  import tollPkg::*;
#(
  parameter  int TOLL   = 35,
  parameter  int COIN_A = 5,
  parameter  int COIN_B = 10,
  parameter  int COIN_C = 25,
  localparam int CW     = $clog2(TOLL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          carHere,
  input  logic [1:0]    coinCode,
  output logic          lampRed,
  output logic          lampGreen,
  output logic          lampAlarm,
  output logic [CW-1:0] creditLevel
);

  creditCtl_t ctl;
  logic       willPay;

  tollFsm uCtrl (
    .clk       (clk),
    .rst       (rst),
    .carHere   (carHere),
    .willPay   (willPay),
    .ctl       (ctl),
    .lampRed   (lampRed),
    .lampGreen (lampGreen),
    .lampAlarm (lampAlarm)
  );

  tollCredit #(
    .TOLL   (TOLL),
    .COIN_A (COIN_A),
    .COIN_B (COIN_B),
    .COIN_C (COIN_C),
    .CW     (CW)
  ) uCredit (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .coinCode (coinCode),
    .credit   (creditLevel),
    .willPay  (willPay)
  );

endmodule

// File: tb/tollBoothCtrl_test.sv
module tollBoothCtrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       carHere = 1'b0;
  logic [1:0] coinCode = 2'b00;
  logic       lampRed, lampGreen, lampAlarm;
  logic [5:0] creditLevel;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic       r;
    logic       g;
    logic       a;
    logic [5:0] c;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  tollBoothCtrl uut (
    .clk         (clk),
    .rst         (rst),
    .carHere     (carHere),
    .coinCode    (coinCode),
    .lampRed     (lampRed),
    .lampGreen   (lampGreen),
    .lampAlarm   (lampAlarm),
    .creditLevel (creditLevel)
  );

  task automatic check(input expItem_t e);
    compared++;
    if (lampRed !== e.r || lampGreen !== e.g || lampAlarm !== e.a || creditLevel !== e.c) begin
      mismatched++;
      $display("FAIL %s: got r=%b g=%b a=%b credit=%0d, expected r=%b g=%b a=%b credit=%0d",
               e.tag, lampRed, lampGreen, lampAlarm, creditLevel, e.r, e.g, e.a, e.c);
    end
  endtask

  // monitor: results appear after the edge that follows the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) check(expQ.pop_front());
    end
  end

  task automatic step(input logic doRst, input logic car, input logic [1:0] coin,
                      input logic r, input logic g, input logic a,
                      input int cred, input string tag);
    expItem_t e;
    @(negedge clk);
    rst      = doRst;
    carHere  = car;
    coinCode = coin;
    e.r = r; e.g = g; e.a = a; e.c = 6'(cred); e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    step(1, 0, 2'b00, 0, 0, 0, 0,  "R1 reset state");
    step(0, 0, 2'b11, 0, 0, 0, 0,  "R6 coin with no car");
    step(0, 1, 2'b01, 1, 0, 0, 5,  "R11 coin on arrival");
    step(0, 1, 2'b10, 1, 0, 0, 15, "R2 ten adds");
    step(0, 1, 2'b00, 1, 0, 0, 15, "R2 no coin");
    step(0, 1, 2'b01, 1, 0, 0, 20, "R2 five adds");
    step(0, 1, 2'b10, 1, 0, 0, 30, "R3 red below toll");
    step(0, 1, 2'b11, 0, 1, 0, 35, "R5 overpay saturates, R4 green");
    step(0, 1, 2'b11, 0, 1, 0, 35, "R10 coin after paid");
    step(0, 0, 2'b00, 0, 0, 0, 0,  "R7 paid car leaves");
    step(0, 1, 2'b11, 1, 0, 0, 25, "R2 quarter adds");
    step(0, 0, 2'b00, 1, 0, 1, 0,  "R8 runaway alarm");
    step(0, 0, 2'b10, 1, 0, 1, 0,  "R8 alarm holds, R6 coin ignored");
    step(0, 0, 2'b00, 1, 0, 1, 0,  "R8 alarm persists");
    step(0, 1, 2'b10, 1, 0, 0, 10, "R9 new car clears alarm");
    step(0, 1, 2'b11, 0, 1, 0, 35, "R4 exact toll");
    step(0, 1, 2'b00, 0, 1, 0, 35, "R10 green holds");
    step(0, 0, 2'b00, 0, 0, 0, 0,  "R7 leave to idle");
    step(0, 1, 2'b00, 1, 0, 0, 0,  "R3 car with no coin");
    step(0, 1, 2'b10, 1, 0, 0, 10, "R2 partial credit");
    step(1, 1, 2'b11, 0, 0, 0, 0,  "R1 reset mid transaction");
    step(0, 1, 2'b11, 1, 0, 0, 25, "R11 arrival after reset");
    step(0, 1, 2'b10, 0, 1, 0, 35, "R4 paid after reset");
    step(0, 0, 2'b00, 0, 0, 0, 0,  "R7 final leave");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule